// File: doc/BRIEF.md
# Synchronous Adapter Control Ports and Interrupt Combiner

This block is the control register front end of a synchronous serial adapter. A host reaches it over a small bus with a 2-bit address, a byte of write data, and separate read and write strobes. Behind that bus sit three 8-bit general ports (A, B and C) and a configuration word that sets each port's direction. Port C splits into an upper and a lower nibble, and each nibble takes its own direction. Ports configured as outputs drive modem control lines, timer gates, clock gates and the hold-in-reset line of the serial controller. Ports configured as inputs sense modem status and timer outputs through a two-flop synchronizer.

The block also builds the adapter's single level interrupt request. The request combines two timer timeout outputs, which arrive on port A bits 7 and 6, with a receive-ready input. Two enables gate it: an active-high timer enable on port B bit 7 and an active-low master enable on port C bit 3. In normal use the host writes configuration word 98h. That makes port A and the upper half of port C inputs, and port B and the lower half of port C outputs. The host then pulses port B bit 4 high and low to reset the serial controller, and sets the remaining enables.

Every register address has fixed meaning and fixed one-cycle write timing. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. A strobe is accepted on the clock edge where it is high.

Top module: `adctl_glue`

## Requirements
- R1: While and after reset, all three ports are inputs. All output latches are 0. Every port output pin reads 1 (idle level, not driven), `ser_reset` is 1 and `irq` is 0.
- R2: A write to address 3 with bit 7 = 1 loads the configuration on the next clock edge. A 1 means input: bit 4 for port A, bit 1 for port B, bit 3 for the upper nibble of port C and bit 0 for its lower nibble. Bits 6, 5 and 2 have no effect. So 98h gives A in, B out, C upper in, C lower out.
- R3: A configuration write (address 3, bit 7 = 1) clears all three output latches to 0 on the same edge.
- R4: A write to address 0, 1 or 2 loads that port's latch on the next edge, whatever the port's direction. A pin driven by an output-configured bit shows its latch bit. A pin on an input-configured bit shows 1.
- R5: A read returns a value in the same cycle, with no added cycle of delay. Addresses 0, 1 and 2 return, per bit, the latch value for output bits and the synchronized pin value for input bits. Address 3 returns 0. With `rd` low, `rdata` is 0.
- R6: A change on any input pin, or on `rx_ready`, reaches reads and the interrupt logic after exactly two rising clock edges.
- R7: A write to address 3 with bit 7 = 0 changes only port C latch bit n, where n is write bits 3..1. The bit takes the value of write bit 0. The other latch bits and the configuration are unchanged.
- R8: `ser_reset` equals port B output pin bit 4, so a 1 holds the serial controller in reset and a high-then-low pulse resets it.
- R9: `irq` is 1 exactly when port C output pin bit 3 is 0 and either receive-ready (synchronized) is 1, or port B output pin bit 7 is 1 and a synchronized timer line (port A bit 7 or bit 6) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = configuration/bit set |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one access per high cycle |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational from addr and rd |
| pa_pins_in | input | 8 | Port A sense pins (bit 7 timer 1, bit 6 timer 2, bit 5 transmit-ready, bit 3 clear-to-send low, bit 1 carrier low, bit 0 ring low) |
| pa_pins_out | output | 8 | Port A output pins |
| pb_pins_in | input | 8 | Port B sense pins |
| pb_pins_out | output | 8 | Port B pins (bit 7 timer IRQ enable, 6/5 timer gates, 4 controller reset, 2..0 active-low test/standby/rate select) |
| pc_pins_in | input | 8 | Port C sense pins (bit 7 adapter type, reads 0; bit 6 test indicate low) |
| pc_pins_out | output | 8 | Port C pins (bit 3 active-low IRQ enable, 2 wrap, 1 external clock gate, 0 internal clock gate) |
| rx_ready | input | 1 | Receive-ready from the serial controller |
| ser_reset | output | 1 | Hold-in-reset to the serial controller |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded checks assume the host never raises `rd` and `wr` in the same cycle. One property flags any cycle where it does. They also assume the pins are ordinary synchronous-world levels, so the synchronizer checks only compare values two edges apart. The stimulus meets both assumptions: each cycle it picks exactly one of idle, read or write. It draws pin values from `$urandom` and changes them only at the falling edge. Directed passes then cover the 98h configuration, the reset pulse, single-bit set and clear, synchronizer latency, and each interrupt enable combination.

// File: rtl/adctl_pkg.sv
package adctl_pkg;
  localparam int DW = 8;
  localparam int HW = DW / 2;

  localparam logic [1:0] ADR_A   = 2'd0;
  localparam logic [1:0] ADR_B   = 2'd1;
  localparam logic [1:0] ADR_C   = 2'd2;
  localparam logic [1:0] ADR_CFG = 2'd3;

  // configuration word bit positions (1 = input)
  localparam int CFG_FLAG = 7;
  localparam int CFG_A    = 4;
  localparam int CFG_CU   = 3;
  localparam int CFG_B    = 1;
  localparam int CFG_CL   = 0;

  // signal positions on the ports
  localparam int PA_TMR1   = 7;
  localparam int PA_TMR2   = 6;
  localparam int PB_TMR_EN = 7;
  localparam int PB_SRST   = 4;
  localparam int PC_IRQ_N  = 3;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/adctl_sync.sv
module adctl_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R6
  two_edge_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/adctl_mode.sv
module adctl_mode
  import adctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [DW-1:0] wdata,
  output dir_t          dir,
  output logic          clr_all,
  output logic          bit_we,
  output logic [2:0]    bit_sel,
  output logic          bit_val
);
  logic cfg_load;
  logic unused_mode_bits;

  assign cfg_load = cfg_wr && wdata[CFG_FLAG];
  assign clr_all  = cfg_load;
  assign bit_we   = cfg_wr && !wdata[CFG_FLAG];
  assign bit_sel  = wdata[3:1];
  assign bit_val  = wdata[0];
  // group-mode select bits: only the basic mode exists, so they are ignored
  assign unused_mode_bits = ^{wdata[6:5], wdata[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= DIR_RESET;
    end else if (cfg_load) begin
      dir.a_in  <= wdata[CFG_A];
      dir.b_in  <= wdata[CFG_B];
      dir.cu_in <= wdata[CFG_CU];
      dir.cl_in <= wdata[CFG_CL];
    end
  end

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (dir.a_in == $past(wdata[CFG_A])) && (dir.b_in == $past(wdata[CFG_B]))
                 && (dir.cu_in == $past(wdata[CFG_CU])) && (dir.cl_in == $past(wdata[CFG_CL])));

  // R7
  bitset_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we |=> $stable(dir));
endmodule

// File: rtl/adctl_port.sv
module adctl_port #(
  parameter int W = 8,
  parameter bit HAS_BITSET = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 we,
  input  logic [W-1:0]         wdata,
  input  logic                 bit_we,
  input  logic [$clog2(W)-1:0] bit_sel,
  input  logic                 bit_val,
  input  logic [W-1:0]         is_out,
  input  logic [W-1:0]         pin_sync,
  output logic [W-1:0]         pin_out,
  output logic [W-1:0]         rd_val
);
  logic [W-1:0] latch;
  logic [W-1:0] latch_nxt;

  generate
    if (HAS_BITSET) begin : g_bitset
      always_comb begin
        latch_nxt = latch;
        if (clr) latch_nxt = '0;
        else if (we) latch_nxt = wdata;
        else if (bit_we) latch_nxt[bit_sel] = bit_val;
      end
    end else begin : g_plain
      logic unused_bitset;
      assign unused_bitset = ^{bit_we, bit_sel, bit_val};
      always_comb begin
        latch_nxt = latch;
        if (clr) latch_nxt = '0;
        else if (we) latch_nxt = wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch <= '0;
    else        latch <= latch_nxt;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pin_out[i] = is_out[i] ? latch[i] : 1'b1;
    assign rd_val[i]  = is_out[i] ? latch[i] : pin_sync[i];
  end

  // R3
  clr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (latch == '0));

  // R4
  write_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (latch == $past(wdata)));
endmodule

// File: rtl/adctl_irq.sv
module adctl_irq (
  input  logic en_n,
  input  logic tmr_en,
  input  logic tmr1,
  input  logic tmr2,
  input  logic rx_rdy,
  output logic irq
);
  logic tmr_req;
  assign tmr_req = tmr_en && (tmr1 || tmr2);
  assign irq     = !en_n && (tmr_req || rx_rdy);
endmodule

// File: rtl/adctl_glue.sv
module adctl_glue
  import adctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_pins_in,
  output logic [DW-1:0] pa_pins_out,
  input  logic [DW-1:0] pb_pins_in,
  output logic [DW-1:0] pb_pins_out,
  input  logic [DW-1:0] pc_pins_in,
  output logic [DW-1:0] pc_pins_out,
  input  logic          rx_ready,
  output logic          ser_reset,
  output logic          irq
);
  localparam int SW = 3 * DW + 1;

  dir_t          dir;
  logic          clr_all, bit_we, bit_val;
  logic [2:0]    bit_sel;
  logic [SW-1:0] sync_out;
  logic [DW-1:0] a_sync, b_sync, c_sync;
  logic          rx_sync;
  logic [DW-1:0] a_rd, b_rd, c_rd;
  logic [DW-1:0] a_dir, b_dir, c_dir;

  adctl_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({rx_ready, pc_pins_in, pb_pins_in, pa_pins_in}),
    .dout(sync_out)
  );
  assign {rx_sync, c_sync, b_sync, a_sync} = sync_out;

  adctl_mode u_mode (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(wr && addr == ADR_CFG), .wdata(wdata),
    .dir(dir), .clr_all(clr_all),
    .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val)
  );

  assign a_dir = {DW{!dir.a_in}};
  assign b_dir = {DW{!dir.b_in}};
  assign c_dir = {{HW{!dir.cu_in}}, {HW{!dir.cl_in}}};

  adctl_port #(.W(DW), .HAS_BITSET(1'b0)) u_pa (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .we(wr && addr == ADR_A), .wdata(wdata),
    .bit_we(1'b0), .bit_sel(3'd0), .bit_val(1'b0),
    .is_out(a_dir), .pin_sync(a_sync),
    .pin_out(pa_pins_out), .rd_val(a_rd)
  );

  adctl_port #(.W(DW), .HAS_BITSET(1'b0)) u_pb (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .we(wr && addr == ADR_B), .wdata(wdata),
    .bit_we(1'b0), .bit_sel(3'd0), .bit_val(1'b0),
    .is_out(b_dir), .pin_sync(b_sync),
    .pin_out(pb_pins_out), .rd_val(b_rd)
  );

  adctl_port #(.W(DW), .HAS_BITSET(1'b1)) u_pc (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .we(wr && addr == ADR_C), .wdata(wdata),
    .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val),
    .is_out(c_dir), .pin_sync(c_sync),
    .pin_out(pc_pins_out), .rd_val(c_rd)
  );

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        ADR_A:   rdata = a_rd;
        ADR_B:   rdata = b_rd;
        ADR_C:   rdata = c_rd;
        default: rdata = '0;
      endcase
    end
  end

  assign ser_reset = pb_pins_out[PB_SRST];

  adctl_irq u_irq (
    .en_n(pc_pins_out[PC_IRQ_N]), .tmr_en(pb_pins_out[PB_TMR_EN]),
    .tmr1(a_sync[PA_TMR1]), .tmr2(a_sync[PA_TMR2]),
    .rx_rdy(rx_sync), .irq(irq)
  );

  // R5 (host bus rule: never both strobes)
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !pc_pins_out[PC_IRQ_N]);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (u_sync.dout[SW-1] || a_sync[PA_TMR1] || a_sync[PA_TMR2]));

  // R8
  reset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_B && !dir.b_in) |=> (ser_reset == $past(wdata[PB_SRST])));
endmodule

// File: tb/adctl_glue_test.sv
module adctl_glue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pb_out, pc_out;
  logic       rx = 1'b0;
  logic       ser_reset, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adctl_glue uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .pa_pins_in(pa_in), .pa_pins_out(pa_out),
    .pb_pins_in(pb_in), .pb_pins_out(pb_out), .pc_pins_in(pc_in),
    .pc_pins_out(pc_out), .rx_ready(rx), .ser_reset(ser_reset), .irq(irq)
  );

  // reference state
  logic [7:0] m_la, m_lb, m_lc;
  logic       m_ain, m_bin, m_cuin, m_clin;
  logic [24:0] m_s1, m_s2;

  function automatic logic [7:0] mask_a(); return m_ain ? 8'h00 : 8'hFF; endfunction
  function automatic logic [7:0] mask_b(); return m_bin ? 8'h00 : 8'hFF; endfunction
  function automatic logic [7:0] mask_c();
    return {m_cuin ? 4'h0 : 4'hF, m_clin ? 4'h0 : 4'hF};
  endfunction
  function automatic logic [7:0] pin_of(logic [7:0] l, logic [7:0] m);
    return (l & m) | ~m;
  endfunction
  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return (m_la & mask_a()) | (m_s2[7:0] & ~mask_a());
      2'd1: return (m_lb & mask_b()) | (m_s2[15:8] & ~mask_b());
      2'd2: return (m_lc & mask_c()) | (m_s2[23:16] & ~mask_c());
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic exp_irq();
    logic [7:0] pb, pc;
    pb = pin_of(m_lb, mask_b());
    pc = pin_of(m_lc, mask_c());
    return !pc[3] && ((pb[7] && (m_s2[7] || m_s2[6])) || m_s2[24]);
  endfunction

  task automatic model_reset();
    m_la = 0; m_lb = 0; m_lc = 0;
    m_ain = 1; m_bin = 1; m_cuin = 1; m_clin = 1;
    m_s1 = 0; m_s2 = 0;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic [1:0] a, logic [7:0] d, logic w, logic r,
                      logic [7:0] pa, logic [7:0] pb, logic [7:0] pc, logic rxv);
    @(negedge clk);
    addr = a; wdata = d; wr = w; rd = r;
    pa_in = pa; pb_in = pb; pc_in = pc; rx = rxv;
    #1;
    check("R5", rdata, r ? exp_read(a) : 8'h00);
    @(posedge clk);
    if (w) begin
      case (a)
        2'd0: m_la = d;
        2'd1: m_lb = d;
        2'd2: m_lc = d;
        default:
          if (d[7]) begin
            m_ain = d[4]; m_bin = d[1]; m_cuin = d[3]; m_clin = d[0];
            m_la = 0; m_lb = 0; m_lc = 0;
          end else m_lc[d[3:1]] = d[0];
      endcase
    end
    m_s2 = m_s1;
    m_s1 = {rxv, pc, pb, pa};
    #1;
    check("R4", pa_out, pin_of(m_la, mask_a()));
    check("R4", pb_out, pin_of(m_lb, mask_b()));
    check("R4", pc_out, pin_of(m_lc, mask_c()));
    check("R8", {7'd0, ser_reset}, {7'd0, pin_of(m_lb, mask_b()) >> 4} & 8'h01);
    check("R9", {7'd0, irq}, {7'd0, exp_irq()});
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    step(a, d, 1'b1, 1'b0, pa_in, pb_in, pc_in, rx);
  endtask
  task automatic idle();
    step(2'd0, 8'h00, 1'b0, 1'b0, pa_in, pb_in, pc_in, rx);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", pa_out, 8'hFF);
    check("R1", pb_out, 8'hFF);
    check("R1", pc_out, 8'hFF);
    check("R1", {7'd0, ser_reset}, 8'h01);
    check("R1", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R2: 98h configuration, with unused bits varied
    wr_reg(2'd1, 8'hAA);
    wr_reg(2'd3, 8'h98);
    check("R2", pb_out, 8'h00);
    check("R2", pc_out, 8'hF0);
    check("R2", pa_out, 8'hFF);
    wr_reg(2'd3, 8'hFC); // 6,5,2 set: same directions as 98h
    check("R2", pc_out, 8'hF0);

    // R3: configuration clears latches
    wr_reg(2'd2, 8'h0F);
    wr_reg(2'd1, 8'h55);
    check("R3", pb_out, 8'h55);
    wr_reg(2'd3, 8'h98);
    check("R3", pb_out, 8'h00);
    check("R3", pc_out, 8'hF0);

    // R8: reset pulse
    wr_reg(2'd1, 8'h10);
    check("R8", {7'd0, ser_reset}, 8'h01);
    wr_reg(2'd1, 8'h00);
    check("R8", {7'd0, ser_reset}, 8'h00);

    // R7: single bit set and clear on port C
    wr_reg(2'd2, 8'h05);
    wr_reg(2'd3, 8'h03); // bit1 <- 1
    check("R7", pc_out, 8'hF7);
    wr_reg(2'd3, 8'h00); // bit0 <- 0
    check("R7", pc_out, 8'hF6);
    wr_reg(2'd3, 8'h0F); // bit7 <- 1 (upper nibble is input: pin stays 1)
    check("R7", pb_out, 8'h00);

    // R6: two-edge latency on a read of port A
    step(2'd0, 8'h00, 1'b0, 1'b0, 8'h3C, pb_in, pc_in, 1'b0);
    idle();
    step(2'd0, 8'h00, 1'b0, 1'b0, 8'hC3, pb_in, pc_in, 1'b0);
    @(negedge clk); rd = 1'b1; addr = 2'd0; #1; rv = rdata;
    check("R6", rv, 8'h3C);
    @(posedge clk); #1; @(negedge clk); #1; rv = rdata;
    check("R6", rv, 8'hC3);
    rd = 1'b0;
    m_s2 = {rx, pc_in, pb_in, pa_in}; m_s1 = m_s2;

    // R9: interrupt enable combinations
    wr_reg(2'd2, 8'h08);            // master enable off
    step(2'd0, 0, 0, 0, 8'hC0, pb_in, pc_in, 1'b1); idle(); idle();
    check("R9", {7'd0, irq}, 8'h00);
    wr_reg(2'd2, 8'h00);            // master on, rx high
    check("R9", {7'd0, irq}, 8'h01);
    step(2'd0, 0, 0, 0, 8'h40, pb_in, pc_in, 1'b0); idle(); idle();
    check("R9", {7'd0, irq}, 8'h00); // timer high but timer enable off
    wr_reg(2'd1, 8'h80);
    check("R9", {7'd0, irq}, 8'h01);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [1:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      a  = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      if (op == 0 && a == 2'd3) d = 8'h98;
      step(a, d, op < 4, op >= 4 && op < 8,
           (op == 9) ? 8'($urandom) : pa_in,
           (op == 9) ? 8'($urandom) : pb_in,
           (op == 9) ? 8'($urandom) & 8'h7F : pc_in,
           (op == 9) ? 1'($urandom) : rx);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule